// File: doc/BRIEF.md
# Delay Tap Drift Compensator

This block keeps two delay-line tap settings valid as the silicon's gate speed drifts with temperature and supply. When triggered, it asks an external speed-measurement circuit for sixteen samples, one after another, and adds them up. A faster chip gives larger samples and therefore a larger sum. It then rescales the command-path tap and the feedback-clock tap that were found during training. Each tap is multiplied by the new sum and divided by the reference sum taken at training time.

The division is done in a sequential restoring divider, with one instance per tap. Each result saturates at the top of the 5-bit tap range. Both results are packed, together with a constant clock-output tap, into one 32-bit control word. That word is registered and changes only when a full computation ends. A busy flag covers the whole run, and triggers that arrive while busy are dropped.

Top module: `tap_drift_scaler`

## Requirements
- R1: While reset is low, and on the first cycle after it, `busy_o` is 0, `ctl_word_o` is 0 and `meas_req_o` is 0.
- R2: A trigger sampled while idle makes `busy_o` 1 on the next cycle. In that same cycle `meas_req_o` equals 0x4000: bit 14 is the start request and all other bits are 0.
- R3: One run issues exactly 16 start requests, each high for one cycle. Each request after the first comes only once the previous sample has been accepted. A sample is accepted when response bit 15 is 1, and its value is response bits 7:0. Bits 14:8 of the response are ignored.
- R4: With a nonzero reference R and a sample sum S, each new tap is floor(base_tap * S / R). This is computed separately for the command tap and the feedback tap.
- R5: A new tap whose quotient exceeds 31 is written as 31.
- R6: When the reference is 0, each new tap equals its base tap.
- R7: The control word carries the command tap in bits 4:0 and the feedback tap in bits 12:8. It carries the constant clock-output tap (0) in bits 20:16 and in bits 28:24, and every other bit is 0.
- R8: `ctl_word_o` changes only on the clock edge where `busy_o` falls. It stays stable in every other cycle.
- R9: A trigger that arrives while `busy_o` is 1 is ignored. No extra start requests follow the run, and the block returns to idle.
- R10: `capture_i` latches `ref_val_i` as the reference. A run uses the reference and base taps present at its trigger, so a capture or a tap change during a run affects only later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trigger_i | input | 1 | Start a rescaling run (ignored while busy) |
| capture_i | input | 1 | Latch `ref_val_i` as the training-time reference sum |
| ref_val_i | input | SAMPLE_W+log2(NUM_SAMPLES) (12) | Reference sum to be captured |
| cmd_tap_i | input | TAP_W (5) | Trained command-path tap |
| fb_tap_i | input | TAP_W (5) | Trained feedback-clock tap |
| meas_req_o | output | 16 | Measurement request word; bit 14 is the start pulse |
| meas_rsp_i | input | 16 | Measurement response; bit 15 is done, bits 7:0 are the value |
| busy_o | output | 1 | High from the cycle after an accepted trigger until the word updates |
| ctl_word_o | output | 32 | Registered packed delay control word |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 16 samples per run and 5-bit taps. With these settings the product and the quotient stay small enough that every expected tap is plain integer arithmetic in the bench. All 32 command-tap values are swept, with the feedback tap mirrored, against four reference ratios: equal to the sum, twice it, half of it, and zero. This covers exact pass-through, truncating division, saturation and the zero-reference bypass for every tap value. Response latency, stray bits in the response word, triggers during a run, and a capture during a run are varied alongside the sweep.

// File: rtl/tds_pkg.sv
// Package: shared constants and state types for the delay tap drift scaler.
// Assumes a 16-bit request/response word and a 32-bit control word with
// byte-aligned tap fields.
package tds_pkg;

    localparam int REQ_W         = 16;
    localparam int REQ_START_BIT = 14;
    localparam int RSP_DONE_BIT  = 15;

    localparam int WORD_W        = 32;
    localparam int FIELD_STRIDE  = 8;
    localparam int CMD_LSB       = 0 * FIELD_STRIDE;
    localparam int FB_LSB        = 1 * FIELD_STRIDE;
    localparam int CKO_A_LSB     = 2 * FIELD_STRIDE;
    localparam int CKO_B_LSB     = 3 * FIELD_STRIDE;

    typedef enum logic [1:0] {
        SMP_IDLE,
        SMP_REQ,
        SMP_WAIT
    } smp_state_e;

    typedef enum logic {
        DIV_IDLE,
        DIV_RUN
    } div_state_e;

endpackage

// File: rtl/tds_sampler.sv
// Sample collector: issues NUM_SAMPLES one-cycle start requests in sequence,
// waits for each done flag and sums the sample values.
// Assumes the measurement circuit drops done after seeing a new start.
module tds_sampler
    import tds_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int NUM_SAMPLES = 16,
    parameter int SUM_W       = SAMPLE_W + $clog2(NUM_SAMPLES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    output logic                start_o,
    input  logic                done_i,
    input  logic [SAMPLE_W-1:0] val_i,
    output logic [SUM_W-1:0]    sum_o,
    output logic                fin_o
);

    localparam int CNT_W = (NUM_SAMPLES > 1) ? $clog2(NUM_SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SAMPLES - 1);

    smp_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SUM_W-1:0]   sum_q;
    logic               fin_q;

    // Sequence the request/wait handshake and accumulate accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SMP_IDLE;
            cnt_q   <= '0;
            sum_q   <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                SMP_IDLE: begin
                    if (go_i) begin
                        sum_q   <= '0;
                        cnt_q   <= '0;
                        state_q <= SMP_REQ;
                    end
                end
                SMP_REQ: begin
                    state_q <= SMP_WAIT;
                end
                SMP_WAIT: begin
                    if (done_i) begin
                        sum_q <= sum_q + SUM_W'(val_i);
                        if (cnt_q == LAST_IDX) begin
                            state_q <= SMP_IDLE;
                            fin_q   <= 1'b1;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= SMP_REQ;
                        end
                    end
                end
                default: state_q <= SMP_IDLE;
            endcase
        end
    end

    // Start request is high for exactly the one cycle spent in SMP_REQ.
    assign start_o = (state_q == SMP_REQ);
    assign sum_o   = sum_q;
    assign fin_o   = fin_q;

endmodule

// File: rtl/tds_divider.sv
// Tap rescaler: computes floor(tap * sum / den) with a restoring divider,
// one quotient bit per cycle, then saturates to the tap range.
// A zero denominator bypasses the scaling and returns the tap unchanged.
// Latency is a fixed TAP_W+SUM_W cycles from load to the fin pulse.
module tds_divider
    import tds_pkg::*;
#(
    parameter int TAP_W = 5,
    parameter int SUM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TAP_W-1:0] tap_i,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [SUM_W-1:0] den_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             fin_o
);

    localparam int NUM_W  = TAP_W + SUM_W;
    localparam int ITER_W = $clog2(NUM_W + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    div_state_e         state_q;
    logic [NUM_W-1:0]   num_q;
    logic [SUM_W:0]     rem_q;
    logic [SUM_W-1:0]   den_q;
    logic [TAP_W-1:0]   tap_q;
    logic [ITER_W-1:0]  iter_q;
    logic [TAP_W-1:0]   res_q;
    logic               fin_q;

    logic [SUM_W+1:0]   rem_shift;
    logic               fits;
    logic [SUM_W:0]     rem_next;
    logic [NUM_W-1:0]   num_next;

    // One restoring step: bring in the next dividend bit, trial-subtract.
    always_comb begin
        rem_shift = {rem_q, num_q[NUM_W-1]};
        fits      = (rem_shift >= (SUM_W+2)'(den_q));
        rem_next  = fits ? (SUM_W+1)'(rem_shift - (SUM_W+2)'(den_q))
                         : (SUM_W+1)'(rem_shift);
        num_next  = {num_q[NUM_W-2:0], fits};
    end

    // Load the product, iterate NUM_W steps, then saturate or bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
            num_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            tap_q   <= '0;
            iter_q  <= '0;
            res_q   <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                DIV_IDLE: begin
                    if (load_i) begin
                        num_q   <= NUM_W'(tap_i) * NUM_W'(sum_i);
                        rem_q   <= '0;
                        den_q   <= den_i;
                        tap_q   <= tap_i;
                        iter_q  <= ITER_W'(NUM_W);
                        state_q <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    num_q  <= num_next;
                    rem_q  <= rem_next;
                    iter_q <= iter_q - 1'b1;
                    if (iter_q == ITER_W'(1)) begin
                        state_q <= DIV_IDLE;
                        fin_q   <= 1'b1;
                        if (den_q == '0) begin
                            res_q <= tap_q;
                        end else if (num_next > NUM_W'(TAP_MAX)) begin
                            res_q <= TAP_MAX;
                        end else begin
                            res_q <= num_next[TAP_W-1:0];
                        end
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

    assign tap_o = res_q;
    assign fin_o = fin_q;

endmodule

// File: rtl/tap_drift_scaler.sv
// Top: accepts a trigger when idle, snapshots the trained taps and reference,
// gathers a measurement sum, rescales both taps in parallel dividers and
// packs them into a registered control word that updates once per run.
// Assumes SAMPLE_W <= 14 and TAP_W <= 8 so fields do not overlap.
module tap_drift_scaler
    import tds_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int NUM_SAMPLES = 16,
    parameter int TAP_W       = 5,
    parameter int CKO_TAP     = 0,
    localparam int SUM_W      = SAMPLE_W + $clog2(NUM_SAMPLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger_i,
    input  logic              capture_i,
    input  logic [SUM_W-1:0]  ref_val_i,
    input  logic [TAP_W-1:0]  cmd_tap_i,
    input  logic [TAP_W-1:0]  fb_tap_i,
    output logic [REQ_W-1:0]  meas_req_o,
    input  logic [REQ_W-1:0]  meas_rsp_i,
    output logic              busy_o,
    output logic [WORD_W-1:0] ctl_word_o
);

    localparam int NUM_CH = 2;
    localparam int CH_CMD = 0;
    localparam int CH_FB  = 1;
    localparam logic [TAP_W-1:0] CKO_VAL = TAP_W'(CKO_TAP);

    logic               busy_q;
    logic [WORD_W-1:0]  word_q;
    logic [SUM_W-1:0]   ref_q;
    logic [SUM_W-1:0]   snap_ref_q;
    logic [TAP_W-1:0]   tap_in   [NUM_CH];
    logic [TAP_W-1:0]   snap_tap_q [NUM_CH];
    logic [TAP_W-1:0]   new_tap  [NUM_CH];
    logic [NUM_CH-1:0]  div_fin;
    logic               accept;
    logic               smp_start;
    logic [SUM_W-1:0]   smp_sum;
    logic               smp_fin;
    logic               all_fin;
    logic [WORD_W-1:0]  word_next;
    logic               unused_rsp_bits;

    assign accept  = trigger_i && !busy_q;
    assign all_fin = &div_fin;
    assign tap_in[CH_CMD] = cmd_tap_i;
    assign tap_in[CH_FB]  = fb_tap_i;
    assign unused_rsp_bits = ^meas_rsp_i[RSP_DONE_BIT-1:SAMPLE_W];

    // Hold the training-time reference sum until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (capture_i) begin
            ref_q <= ref_val_i;
        end
    end

    // Freeze reference and trained taps at the accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ref_q <= '0;
            for (int c = 0; c < NUM_CH; c++) snap_tap_q[c] <= '0;
        end else if (accept) begin
            snap_ref_q <= ref_q;
            for (int c = 0; c < NUM_CH; c++) snap_tap_q[c] <= tap_in[c];
        end
    end

    tds_sampler #(
        .SAMPLE_W    (SAMPLE_W),
        .NUM_SAMPLES (NUM_SAMPLES),
        .SUM_W       (SUM_W)
    ) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (accept),
        .start_o (smp_start),
        .done_i  (meas_rsp_i[RSP_DONE_BIT]),
        .val_i   (meas_rsp_i[SAMPLE_W-1:0]),
        .sum_o   (smp_sum),
        .fin_o   (smp_fin)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        tds_divider #(
            .TAP_W (TAP_W),
            .SUM_W (SUM_W)
        ) i_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (smp_fin),
            .tap_i  (snap_tap_q[ch]),
            .sum_i  (smp_sum),
            .den_i  (snap_ref_q),
            .tap_o  (new_tap[ch]),
            .fin_o  (div_fin[ch])
        );
    end

    // Assemble the next control word from the scaled taps and fixed fields.
    always_comb begin
        word_next = '0;
        word_next[CMD_LSB   +: TAP_W] = new_tap[CH_CMD];
        word_next[FB_LSB    +: TAP_W] = new_tap[CH_FB];
        word_next[CKO_A_LSB +: TAP_W] = CKO_VAL;
        word_next[CKO_B_LSB +: TAP_W] = CKO_VAL;
    end

    // Busy spans accept to completion; the word loads only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            word_q <= '0;
        end else begin
            if (accept) begin
                busy_q <= 1'b1;
            end else if (all_fin) begin
                busy_q <= 1'b0;
                word_q <= word_next;
            end
        end
    end

    // Request word carries only the start pulse.
    always_comb begin
        meas_req_o = '0;
        meas_req_o[REQ_START_BIT] = smp_start;
    end

    assign busy_o     = busy_q;
    assign ctl_word_o = word_q;

endmodule

// File: rtl/tap_drift_scaler_chk.sv
// Checker: protocol and output-stability properties of the scaler ports.
// Assumes the fixed request/word layout from tds_pkg.
module tap_drift_scaler_chk
    import tds_pkg::*;
#(
    parameter int TAP_W   = 5,
    parameter int CKO_TAP = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trigger_i,
    input logic [REQ_W-1:0]  meas_req_o,
    input logic              busy_o,
    input logic [WORD_W-1:0] ctl_word_o
);

    localparam logic [TAP_W-1:0] CKO_VAL = TAP_W'(CKO_TAP);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && ctl_word_o == '0 && meas_req_o == '0));

    a_r2_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && trigger_i) |=> (busy_o && meas_req_o[REQ_START_BIT]));

    a_r3_start_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o[REQ_START_BIT] |-> busy_o);

    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o[REQ_START_BIT] |=> !meas_req_o[REQ_START_BIT]);

    a_r7_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctl_word_o[CKO_A_LSB +: TAP_W] == CKO_VAL || ctl_word_o == '0));

    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(ctl_word_o)));

    a_r8_hold_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(ctl_word_o));

endmodule

bind tap_drift_scaler tap_drift_scaler_chk #(
    .TAP_W   (TAP_W),
    .CKO_TAP (CKO_TAP)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger_i  (trigger_i),
    .meas_req_o (meas_req_o),
    .busy_o     (busy_o),
    .ctl_word_o (ctl_word_o)
);

// File: tb/test_tap_drift_scaler.sv
module test_tap_drift_scaler;

    localparam int SAMPLE_W    = 8;
    localparam int NUM_SAMPLES = 16;
    localparam int TAP_W       = 5;
    localparam int SUM_W       = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trigger_i = 1'b0;
    logic              capture_i = 1'b0;
    logic [SUM_W-1:0]  ref_val_i = '0;
    logic [TAP_W-1:0]  cmd_tap_i = '0;
    logic [TAP_W-1:0]  fb_tap_i = '0;
    logic [15:0]       meas_req_o;
    logic [15:0]       meas_rsp_i = '0;
    logic              busy_o;
    logic [31:0]       ctl_word_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int ref_now  = 0;

    always #4 clk = ~clk;

    tap_drift_scaler #(
        .SAMPLE_W    (SAMPLE_W),
        .NUM_SAMPLES (NUM_SAMPLES),
        .TAP_W       (TAP_W),
        .CKO_TAP     (0)
    ) i_tap_drift_scaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .trigger_i  (trigger_i),
        .capture_i  (capture_i),
        .ref_val_i  (ref_val_i),
        .cmd_tap_i  (cmd_tap_i),
        .fb_tap_i   (fb_tap_i),
        .meas_req_o (meas_req_o),
        .meas_rsp_i (meas_rsp_i),
        .busy_o     (busy_o),
        .ctl_word_o (ctl_word_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog expired actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int sval(input int seed, input int s);
        return (seed * 53 + s * 29 + 7) % 256;
    endfunction

    function automatic int ssum(input int seed);
        int acc = 0;
        for (int s = 0; s < NUM_SAMPLES; s++) acc += sval(seed, s);
        return acc;
    endfunction

    function automatic int exp_tap(input int tap, input int sum, input int rv);
        int q;
        if (rv == 0) return tap;
        q = (tap * sum) / rv;
        return (q > 31) ? 31 : q;
    endfunction

    task automatic capture_ref(input int v);
        @(negedge clk);
        ref_val_i = SUM_W'(v);
        capture_i = 1'b1;
        @(negedge clk);
        capture_i = 1'b0;
        ref_now = v;
    endtask

    // One full run: trigger, serve 16 samples, wait for completion, check.
    task automatic run(input int ctap, input int ftap, input int seed,
                       input bit poke, input bit recap, input int new_ref,
                       input string force_tag);
        int sum = ssum(seed);
        int used_ref = ref_now;
        logic [31:0] prior;
        int served = 0;
        bit stable_ok = 1'b1;
        bit extra_start = 1'b0;
        int guard;
        int ec, ef, raw;
        string tag;

        @(negedge clk);
        cmd_tap_i = TAP_W'(ctap);
        fb_tap_i  = TAP_W'(ftap);
        prior = ctl_word_o;
        trigger_i = 1'b1;
        @(negedge clk);
        trigger_i = 1'b0;
        // R2: busy and start request one cycle after trigger
        check(busy_o === 1'b1 && meas_req_o === 16'h4000, "R2", meas_req_o, 16'h4000);

        for (int s = 0; s < NUM_SAMPLES; s++) begin
            guard = 0;
            while (!meas_req_o[14] && guard < 40) begin
                if (ctl_word_o !== prior) stable_ok = 1'b0;
                @(negedge clk);
                guard++;
            end
            if (!meas_req_o[14]) break;
            served++;
            @(negedge clk);
            if (s == 2 && (poke || recap)) begin
                trigger_i = poke;
                if (recap) begin
                    capture_i = 1'b1;
                    ref_val_i = SUM_W'(new_ref);
                    cmd_tap_i = ~TAP_W'(ctap);
                    fb_tap_i  = ~TAP_W'(ftap);
                end
                @(negedge clk);
                trigger_i = 1'b0;
                capture_i = 1'b0;
            end
            repeat ((s + seed) % 3) begin
                if (ctl_word_o !== prior) stable_ok = 1'b0;
                @(negedge clk);
            end
            if (ctl_word_o !== prior) stable_ok = 1'b0;
            meas_rsp_i = {1'b1, 7'(s * 5 + seed + 1), 8'(sval(seed, s))};
            @(negedge clk);
            meas_rsp_i = '0;
        end

        guard = 0;
        while (busy_o && guard < 80) begin
            if (meas_req_o[14]) extra_start = 1'b1;
            if (ctl_word_o !== prior) stable_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        if (recap) ref_now = new_ref;

        ec = exp_tap(ctap, sum, used_ref);
        ef = exp_tap(ftap, sum, used_ref);
        raw = (used_ref == 0) ? 0 : (ctap * sum) / used_ref;
        if (force_tag != "") tag = force_tag;
        else if (used_ref == 0) tag = "R6";
        else if (raw > 31) tag = "R5";
        else tag = "R4";

        check(ctl_word_o[4:0] == 5'(ec), {tag, " cmd tap"}, ctl_word_o[4:0], ec);
        check(ctl_word_o[12:8] == 5'(ef), {tag, " fb tap"}, ctl_word_o[12:8], ef);
        // R7: fixed clock-out fields and unused bits
        check(ctl_word_o[20:16] == 5'd0 && ctl_word_o[28:24] == 5'd0 &&
              (ctl_word_o & 32'hE0E0_E0E0) == 32'd0, "R7", ctl_word_o & 32'hFFFF_0000 | ctl_word_o & 32'hE0E0_E0E0, 0);
        // R8: word held until busy falls
        check(stable_ok, "R8", stable_ok, 1);
        // R3: sample count
        check(served == NUM_SAMPLES && !extra_start, "R3", served, NUM_SAMPLES);
        repeat (8) begin
            @(negedge clk);
            if (meas_req_o[14] || busy_o) extra_start = 1'b1;
        end
        // R9 (or R3 for plain runs): nothing more follows the run
        check(!extra_start && !busy_o, poke ? "R9" : "R3", extra_start, 0);
    endtask

    initial begin
        int sum, rv;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check(busy_o === 1'b0 && ctl_word_o === 32'd0 && meas_req_o === 16'd0, "R1", ctl_word_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state just after reset release
        check(busy_o === 1'b0 && ctl_word_o === 32'd0 && meas_req_o === 16'd0, "R1", busy_o, 0);

        for (int rk = 0; rk < 4; rk++) begin
            for (int tap = 0; tap < 32; tap++) begin
                sum = ssum(rk * 3 + tap);
                case (rk)
                    0: rv = sum;
                    1: rv = (sum * 2 > 4095) ? 4095 : sum * 2;
                    2: rv = (sum / 2 == 0) ? 1 : sum / 2;
                    default: rv = 0;
                endcase
                capture_ref(rv);
                run(tap, 31 - tap, rk * 3 + tap, (tap % 5) == 1, 1'b0, 0, "");
            end
        end

        // R5: smallest reference saturates even a tap of 1
        capture_ref(1);
        run(1, 0, 77, 1'b0, 1'b0, 0, "R5");

        // R10: capture and tap change mid-run affect only the next run
        capture_ref(1000);
        run(20, 9, 50, 1'b0, 1'b1, 3000, "R10");
        run(20, 9, 50, 1'b0, 1'b0, 0, "R10");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule